// File: doc/BRIEF.md
# Parallel-Load Serial Word Transmitter

This block turns one parallel data word from a processor bus into a plain serial bit stream on a single output wire. A strobe copies the whole word into a shift register in one cycle. A free-running prescaler then produces a one-cycle shift enable every 2^DIV_W system clocks, and each enable moves the register one stage toward its output end. No start, stop or parity bits are added. Only the data bits leave, most significant bit first. The stages that empty behind the word refill with ones, so the line rests high between words.

With the default DIV_W = 8, the shift rate is the system clock divided by 256. A 2.5 MHz system clock therefore gives close to 9600 bit/s. A strobe also restarts the prescaler, so the first bit is held for a full period. A busy flag stays high while a word is in flight. A one-cycle done pulse marks the end of the last bit period. A strobe issued during a transfer abandons the current word and starts the new one.

Top module: `bitser_tx`

## Requirements
- R1: While reset is asserted and after it is released with no load, `ser_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: A cycle with `load_i` high copies all DATA_W bits of `data_i` into the register. From the next cycle `ser_o` equals `data_i[DATA_W-1]` and `busy_o` is 1.
- R3: Bits leave most significant first. Counting t system cycles after the load edge, `ser_o` shows bit DATA_W-1-floor(t/N), where N = 2^DIV_W, for t < DATA_W*N.
- R4: Each bit, the first one included, stays on `ser_o` for exactly N = 2^DIV_W system cycles. The default N is 256.
- R5: No framing bits are produced. From t = DATA_W*N, `ser_o` is 1, and it stays 1 whenever `busy_o` is 0.
- R6: `busy_o` drops at t = DATA_W*N. `done_o` is 1 for exactly that one cycle and 0 otherwise.
- R7: `load_i` wins over a shift enable in the same cycle. A load during a transfer discards the old word and restarts both the bit timing and the bit count from the new load. This holds even when the load falls on a shift edge.
- R8: Changes on `data_i` while `load_i` is low have no effect on `ser_o`, `busy_o` or `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Parallel load strobe, sampled on the rising clock edge |
| data_i | input | DATA_W | Parallel word to send |
| ser_o | output | 1 | Serial data output, idles high |
| busy_o | output | 1 | High while a word is being shifted out |
| done_o | output | 1 | One-cycle pulse when the last bit period ends |

## Verification
A prescaler phase that is off by even one count shows at the ports. It moves the first bit change of every word away from cycle N after the load, so a per-cycle comparison catches it within the first bit period. A shift-register or bit-counter fault shows within the word itself. It appears as a wrong bit value in some period, as busy dropping early or late, or as a done pulse in the wrong cycle. The bench therefore compares every cycle of every word against values computed from the word and the cycle index, over all 256 word values with a short divider. It then repeats one word at the full divide ratio.

// File: rtl/bsx_pkg.sv
package bsx_pkg;

  // Transfer state of the word sequencer
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } bsx_state_e;

  // Width needed to count 0..n inclusive
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/bsx_rst_sync.sv
module bsx_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;

endmodule

// File: rtl/bsx_prescaler.sv
module bsx_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);

  localparam logic [DIV_W-1:0] PHASE_LAST = '1;

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] phase_d;

  // Next-state: a restart returns the phase to zero so a full period follows
  always_comb begin
    if (restart_i) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign tick_o = (phase_q == PHASE_LAST);

  // R7: a restart pushes the next enable a full period away
  a_r7_restart_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !tick_o);

  // R4: enables are isolated single-cycle pulses
  a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/bsx_shifter.sv
module bsx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ser_o
);

  logic [DATA_W-1:0] stage_q;
  logic [DATA_W-1:0] stage_d;

  // One next-state term per stage; stage 0 takes a 1 as the word moves up
  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_comb begin
        if (load_i) begin
          stage_d[i] = data_i[i];
        end else if (tick_i) begin
          stage_d[i] = 1'b1;
        end else begin
          stage_d[i] = stage_q[i];
        end
      end
    end else begin : g_body
      always_comb begin
        if (load_i) begin
          stage_d[i] = data_i[i];
        end else if (tick_i) begin
          stage_d[i] = stage_q[i-1];
        end else begin
          stage_d[i] = stage_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '1;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign ser_o = stage_q[DATA_W-1];

  // R3: without load or enable the register holds its contents
  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(stage_q));

  // R2: the output stage shows the top data bit right after a load
  a_r2_load_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ser_o == $past(data_i[DATA_W-1])));

endmodule

// File: rtl/bsx_sequencer.sv
module bsx_sequencer
  import bsx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = cnt_width(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  bsx_state_e       state_q;
  bsx_state_e       state_d;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             done_q;
  logic             done_d;

  // Next-state: load has priority, then one count per enable while sending
  always_comb begin
    state_d = state_q;
    count_d = count_q;
    done_d  = 1'b0;
    if (load_i) begin
      state_d = ST_SEND;
      count_d = '0;
    end else if (tick_i && (state_q == ST_SEND)) begin
      if (count_q == CNT_LAST) begin
        state_d = ST_IDLE;
        count_d = CNT_FULL;
        done_d  = 1'b1;
      end else begin
        count_d = count_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      count_q <= count_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == ST_SEND);
  assign done_o = done_q;

  // R6: busy only ever falls together with the done pulse
  a_r6_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R6: the done pulse never coincides with busy and lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o) ##1 !done_o);

  // R6: the shift count never passes the word length
  a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_FULL);

  // R2/R7: any load starts a fresh transfer at count zero
  a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (busy_o && (count_q == '0)));

endmodule

// File: rtl/bitser_tx.sv
module bitser_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ser_o,
  output logic              busy_o,
  output logic              done_o
);

  logic rst_n_sync;
  logic shift_en;

  bsx_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_sync)
  );

  bsx_prescaler #(
    .DIV_W (DIV_W)
  ) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .restart_i (load_i),
    .tick_o    (shift_en)
  );

  bsx_shifter #(
    .DATA_W (DATA_W)
  ) u_shifter (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .load_i (load_i),
    .tick_i (shift_en),
    .data_i (data_i),
    .ser_o  (ser_o)
  );

  bsx_sequencer #(
    .DATA_W (DATA_W)
  ) u_sequencer (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .load_i (load_i),
    .tick_i (shift_en),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  // R5: whenever no word is in flight the line rests high
  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !busy_o |-> ser_o);

endmodule

// File: tb/bitser_tx_test.sv
`timescale 1ns/1ps
module bitser_tx_test;

  localparam int DW      = 8;
  localparam int SMALL_W = 3;
  localparam int N_SMALL = 1 << SMALL_W;
  localparam int N_FULL  = 256;

  logic          clk;
  logic          rst_n;
  logic          load;
  logic [DW-1:0] data;
  logic          ser_s, busy_s, done_s;
  logic          ser_f, busy_f, done_f;

  int checks   = 0;
  int failures = 0;

  bitser_tx #(.DATA_W(DW), .DIV_W(SMALL_W)) uut (
    .clk(clk), .rst_n(rst_n), .load_i(load), .data_i(data),
    .ser_o(ser_s), .busy_o(busy_s), .done_o(done_s)
  );

  bitser_tx #(.DATA_W(DW)) uut_full (
    .clk(clk), .rst_n(rst_n), .load_i(load), .data_i(data),
    .ser_o(ser_f), .busy_o(busy_f), .done_o(done_f)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a load at the current negedge; returns one negedge after the load edge (t = 0)
  task automatic start(input logic [DW-1:0] w);
    data = w;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // Compare every cycle t in [0, limit) with values from the word and t.
  // data_i is scrambled each cycle to exercise R8.
  task automatic watch(input logic [DW-1:0] w, input int n, input bit full, input int limit);
    for (int t = 0; t < limit; t++) begin
      logic s, b, d;
      s = full ? ser_f : ser_s;
      b = full ? busy_f : busy_s;
      d = full ? done_f : done_s;
      if (t < DW * n) begin
        check("R3 R4 R8 bit value", s, w[DW - 1 - t / n]);
        check("R6 busy in flight", b, 1'b1);
        check("R6 no early done", d, 1'b0);
      end else if (t == DW * n) begin
        check("R5 line high after word", s, 1'b1);
        check("R6 busy cleared", b, 1'b0);
        check("R6 done pulse", d, 1'b1);
      end else begin
        check("R5 line stays high", s, 1'b1);
        check("R6 done single cycle", d, 1'b0);
      end
      data = ~w ^ DW'(t);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    load  = 1'b0;
    data  = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1 ser in reset", ser_s, 1'b1);
    check("R1 busy in reset", busy_s, 1'b0);
    check("R1 done in reset", done_s, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R8: idle after release, data toggling without load
    for (int i = 0; i < 40; i++) begin
      data = DW'(i * 37);
      @(negedge clk);
      check("R1 R8 idle ser", ser_s, 1'b1);
      check("R1 R8 idle busy", busy_s, 1'b0);
      check("R1 R8 idle done", done_s, 1'b0);
    end

    // R2 R3 R4 R5 R6: every word value with the short divider
    for (int w = 0; w < 256; w++) begin
      start(DW'(w));
      check("R2 busy after load", busy_s, 1'b1);
      watch(DW'(w), N_SMALL, 1'b0, DW * N_SMALL + 2);
    end

    // R7: load lands exactly on a shift edge (edge 2N after the first load)
    start(8'h3C);
    watch(8'h3C, N_SMALL, 1'b0, 2 * N_SMALL - 1);
    start(8'hA6);
    watch(8'hA6, N_SMALL, 1'b0, DW * N_SMALL + 2);

    // R7: load mid-period during a transfer
    start(8'h81);
    watch(8'h81, N_SMALL, 1'b0, 5);
    start(8'h5E);
    watch(8'h5E, N_SMALL, 1'b0, DW * N_SMALL + 2);

    // R7: back-to-back load after a word with bits already gone
    start(8'hF0);
    watch(8'hF0, N_SMALL, 1'b0, 3 * N_SMALL + 3);
    start(8'h0F);
    watch(8'h0F, N_SMALL, 1'b0, DW * N_SMALL + 2);

    // R4: default divide-by-256 instance, one full word
    start(8'hA5);
    watch(8'hA5, N_FULL, 1'b1, DW * N_FULL + 2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule